// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This unit takes one operand from a 64-bit register image and a 3-bit operand-kind code, and turns it into the single internal form used by the arithmetic stages behind it. That form has a sign bit, a signed 13-bit unbiased exponent, a 64-bit mantissa whose leading one sits at bit 62, and a class code. Signed 32-bit and 64-bit integers and IEEE single and double values all come out in this form. Subnormal inputs are normalized before they leave. A signalling NaN is made quiet in the mantissa, but its class still records that it was signalling, and the invalid-operand flag is raised.

Operands arrive on a valid/ready stream and leave on a second valid/ready stream, with one register stage between them. The input is accepted on any edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained on the same edge. While `out_valid` is high and `out_ready` is low, the output holds every field unchanged, and no new operand is accepted.

Top module: `fp_unpack`

## Requirements
- R1: A result appears one edge after its operand is accepted. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output holds every field unchanged. Results leave in the order their operands were accepted.
- R2: The sign comes from bit 31 of `in_word` for kind 0, and from bit 63 for every other supported kind.
- R3: Kind codes are 0 for a 32-bit integer (taken from `in_word[31:0]`), 1 for a 64-bit integer, 2 for single precision (taken from `in_word[63:32]`) and 3 for double precision. Codes 4 to 7 give class 0, sign 0, exponent 0, mantissa 0 and `out_bad_type` = 1.
- R4: Class codes are ZERO=0, NUM=1, INF=2, QNAN=3 and SNAN=4. A ZERO result has mantissa 0 and exponent 0. Integer zero is ZERO, and so is a float whose exponent field is zero and whose whole fraction is zero. For double precision, the whole fraction includes all of the low 32-bit word.
- R5: For a normal float, bit 62 of the mantissa carries the implied one and the fraction follows from bit 61 downward. The exponent is the biased exponent minus the bias (127 or 1023).
- R6: A subnormal float (exponent field zero, nonzero fraction) gets no implied one. It starts with exponent 1 minus the bias and is then shifted left until its leading one reaches bit 62. The exponent is lowered by the same shift.
- R7: An exponent field of all ones with a zero fraction gives class INF, with mantissa 0 and exponent 0.
- R8: An exponent field of all ones with a nonzero fraction whose top bit is set gives QNAN. The fraction is placed from bit 61 downward, the exponent is 0, and `out_invalid` is 0.
- R9: An all-ones exponent with a nonzero fraction whose top bit is clear gives SNAN. The mantissa is the fraction with bit 61 forced to one, and `out_invalid` is 1. `out_invalid` is never 1 for any other class.
- R10: A nonzero integer gives class NUM. Its magnitude (negative values are negated) is normalized to bit 62, and the exponent equals the position of the magnitude's leading one. The magnitudes 2^31 and 2^63 come out exactly, with exponents 31 and 63.
- R11: Every NUM result has mantissa bits [63:62] equal to 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_kind | input | 3 | Operand kind code |
| in_word | input | 64 | Register image |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result this cycle |
| out_sign | output | 1 | Sign |
| out_exp | output | 13 | Signed unbiased exponent |
| out_mant | output | 64 | Mantissa, leading one at bit 62 |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Signalling-NaN operand seen |
| out_bad_type | output | 1 | Unsupported kind code |

## Verification
The bench targets the corner cases where a plausible bug gives a wrong answer without any obvious symptom. It sends the most negative integers of both widths: a design that negates without extra width would report zero or a negative magnitude. It sends the smallest subnormals: a design that forgets to normalize would leave the leading one below bit 62 with the wrong exponent. It sends a double whose only set bit is in the low word, which a design that tests only the upper fraction would report as ZERO. It sends NaNs that differ only in the top fraction bit, so a design that swaps the quiet and signalling cases, or forgets to set bit 61, shows a class or mantissa mismatch. The same vectors run again with back-pressure on the output, so a design that drops, duplicates or alters a held result fails the order or stability checks.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;
  localparam int MANT_W = 64;
  localparam int EXP_W  = 13;
  localparam int KIND_W = 3;
  localparam int WORD_W = 64;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fclass_e;

  typedef enum logic [KIND_W-1:0] {
    KIND_I32 = 3'd0,
    KIND_I64 = 3'd1,
    KIND_F32 = 3'd2,
    KIND_F64 = 3'd3
  } kind_e;

  typedef struct packed {
    logic                     sign;
    logic signed [EXP_W-1:0]  exp;
    logic [MANT_W-1:0]        mant;
    fclass_e                  cls;
    logic                     invalid;
    logic                     bad_type;
  } unpacked_t;
endpackage

// File: rtl/fpu_lzc.sv
module fpu_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  // Scan upward; the highest set bit writes last and wins.
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpu_norm.sv
module fpu_norm #(
  parameter int MW = 64,
  parameter int EW = 13
) (
  input  logic [MW-1:0]        mant_in,
  input  logic signed [EW-1:0] exp_in,
  output logic [MW-1:0]        mant_out,
  output logic signed [EW-1:0] exp_out
);
  localparam int CW = $clog2(MW + 1);

  logic [CW-1:0] lz;

  fpu_lzc #(.W(MW)) u_lzc (.vec(mant_in), .count(lz));

  // Target leading-one position is MW-2: shift by lz-1, or right by one
  // when the top bit is occupied.
  always_comb begin
    if (lz == '0) begin
      mant_out = mant_in >> 1;
      exp_out  = exp_in + EW'(1);
    end else begin
      mant_out = mant_in << (lz - CW'(1));
      exp_out  = exp_in - EW'(lz - CW'(1));
    end
  end
endmodule

// File: rtl/fpu_ieee_field.sv
module fpu_ieee_field
  import fpu_unpack_pkg::*;
#(
  parameter int EXP_FW  = 8,
  parameter int FRAC_FW = 23,
  parameter int MW      = 64,
  parameter int EW      = 13
) (
  input  logic [EXP_FW+FRAC_FW-1:0] bits,
  output fclass_e                   cls,
  output logic signed [EW-1:0]      exp,
  output logic [MW-1:0]             mant,
  output logic                      sig_nan
);
  localparam int BIAS = (1 << (EXP_FW - 1)) - 1;
  localparam int PAD  = MW - 2 - FRAC_FW;

  logic [EXP_FW-1:0]  efield;
  logic [FRAC_FW-1:0] frac;

  assign efield = bits[EXP_FW+FRAC_FW-1:FRAC_FW];
  assign frac   = bits[FRAC_FW-1:0];

  always_comb begin
    cls     = CLS_NUM;
    exp     = '0;
    mant    = '0;
    sig_nan = 1'b0;
    if (efield == '0) begin
      if (frac == '0) begin
        cls = CLS_ZERO;
      end else begin
        exp  = EW'(1 - BIAS);
        mant = {2'b00, frac, {PAD{1'b0}}};
      end
    end else if (&efield) begin
      if (frac == '0) begin
        cls = CLS_INF;
      end else begin
        mant = {2'b00, frac, {PAD{1'b0}}};
        if (frac[FRAC_FW-1]) begin
          cls = CLS_QNAN;
        end else begin
          cls          = CLS_SNAN;
          sig_nan      = 1'b1;
          mant[MW-3]   = 1'b1;
        end
      end
    end else begin
      exp  = EW'(int'(efield) - BIAS);
      mant = {2'b01, frac, {PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
  import fpu_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [MANT_W-1:0] out_mant,
  output logic [2:0]        out_class,
  output logic              out_invalid,
  output logic              out_bad_type
);
  localparam int N_INT = 2;

  // Integer paths: 32-bit and 64-bit magnitudes.
  logic [MANT_W-1:0] int_mag [N_INT];

  for (genvar g = 0; g < N_INT; g++) begin : g_int
    localparam int IW = 32 << g;
    logic [IW-1:0] raw;
    logic [IW-1:0] mag;
    assign raw        = in_word[IW-1:0];
    assign mag        = raw[IW-1] ? (IW'(0) - raw) : raw;
    assign int_mag[g] = MANT_W'(mag);
  end

  // Float paths.
  fclass_e                   s_cls, d_cls;
  logic signed [EXP_W-1:0]   s_exp, d_exp;
  logic [MANT_W-1:0]         s_mant, d_mant;
  logic                      s_snan, d_snan;

  fpu_ieee_field #(.EXP_FW(8), .FRAC_FW(23), .MW(MANT_W), .EW(EXP_W)) u_sng (
    .bits(in_word[62:32]), .cls(s_cls), .exp(s_exp), .mant(s_mant), .sig_nan(s_snan)
  );

  fpu_ieee_field #(.EXP_FW(11), .FRAC_FW(52), .MW(MANT_W), .EW(EXP_W)) u_dbl (
    .bits(in_word[62:0]), .cls(d_cls), .exp(d_exp), .mant(d_mant), .sig_nan(d_snan)
  );

  // Kind select before normalization.
  logic                    pre_sign, pre_inv, pre_bad;
  fclass_e                 pre_cls;
  logic signed [EXP_W-1:0] pre_exp;
  logic [MANT_W-1:0]       pre_mant;

  always_comb begin
    pre_sign = in_word[WORD_W-1];
    pre_inv  = 1'b0;
    pre_bad  = 1'b0;
    pre_cls  = CLS_ZERO;
    pre_exp  = '0;
    pre_mant = '0;
    case (in_kind)
      KIND_I32, KIND_I64: begin
        pre_sign = (in_kind == KIND_I32) ? in_word[31] : in_word[WORD_W-1];
        pre_mant = int_mag[(in_kind == KIND_I32) ? 0 : 1];
        pre_cls  = (pre_mant == '0) ? CLS_ZERO : CLS_NUM;
        pre_exp  = EXP_W'(MANT_W - 2);
      end
      KIND_F32: begin
        pre_cls  = s_cls;
        pre_exp  = s_exp;
        pre_mant = s_mant;
        pre_inv  = s_snan;
      end
      KIND_F64: begin
        pre_cls  = d_cls;
        pre_exp  = d_exp;
        pre_mant = d_mant;
        pre_inv  = d_snan;
      end
      default: begin
        pre_sign = 1'b0;
        pre_bad  = 1'b1;
      end
    endcase
  end

  logic [MANT_W-1:0]       n_mant;
  logic signed [EXP_W-1:0] n_exp;

  fpu_norm #(.MW(MANT_W), .EW(EXP_W)) u_norm (
    .mant_in(pre_mant), .exp_in(pre_exp), .mant_out(n_mant), .exp_out(n_exp)
  );

  unpacked_t nxt, q;

  always_comb begin
    nxt.sign     = pre_sign;
    nxt.cls      = pre_cls;
    nxt.invalid  = pre_inv;
    nxt.bad_type = pre_bad;
    nxt.mant     = (pre_cls == CLS_NUM) ? n_mant : pre_mant;
    nxt.exp      = (pre_cls == CLS_NUM) ? n_exp : '0;
  end

  // Output register stage with back-pressure.
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) q <= nxt;
    end
  end

  assign out_sign     = q.sign;
  assign out_exp      = q.exp;
  assign out_mant     = q.mant;
  assign out_class    = q.cls;
  assign out_invalid  = q.invalid;
  assign out_bad_type = q.bad_type;
endmodule

// File: rtl/fp_unpack_chk.sv
module fp_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_sign,
  input logic [12:0] out_exp,
  input logic [63:0] out_mant,
  input logic [2:0]  out_class,
  input logic        out_invalid,
  input logic        out_bad_type
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mant) && $stable(out_exp)
                                   && $stable(out_class) && $stable(out_sign)));

  assert_bad_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bad_type) |-> (out_class == 3'd0 && !out_sign));

  assert_zero_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'd0) |-> (out_mant == '0 && out_exp == '0));

  assert_class_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_class <= 3'd4));

  assert_inf_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'd2) |-> (out_mant == '0));

  assert_nan_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_class == 3'd3 || out_class == 3'd4)) |-> out_mant[61]);

  assert_invalid_only_snan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_invalid == (out_class == 3'd4)));

  assert_num_lead_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'd1) |-> (out_mant[63:62] == 2'b01));
endmodule

bind fp_unpack fp_unpack_chk u_chk (.*);

// File: tb/sim_fp_unpack.sv
module sim_fp_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_kind = '0;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_sign;
  logic [12:0] out_exp;
  logic [63:0] out_mant;
  logic [2:0]  out_class;
  logic        out_invalid;
  logic        out_bad_type;

  typedef struct packed {
    logic        sign;
    logic [12:0] exp;
    logic [63:0] mant;
    logic [2:0]  cls;
    logic        inv;
    logic        bad;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad = 0;
  logic  bp_en = 1'b0;
  logic  done = 1'b0;

  always #5 clk = ~clk;

  fp_unpack u0 (.*);

  // Reference model written from the requirements.
  function automatic res_t model(input logic [2:0] k, input logic [63:0] w);
    res_t        r;
    logic [63:0] sig;
    logic [63:0] f;
    int          e, fw, emax, bias, lsb, p;
    logic        num;
    r = '0; sig = '0; f = '0; e = 0; fw = 0; emax = 0; bias = 0; lsb = 0; p = 0; num = 1'b0;
    if (k > 3'd3) begin
      r.bad = 1'b1;
      return r;
    end
    if (k == 3'd0) begin
      r.sign = w[31];
      sig = {32'd0, w[31] ? (32'd0 - w[31:0]) : w[31:0]};
      num = (sig != 0);
    end else if (k == 3'd1) begin
      r.sign = w[63];
      sig = w[63] ? (64'd0 - w) : w;
      num = (sig != 0);
    end else begin
      r.sign = w[63];
      if (k == 3'd2) begin
        fw = 23; emax = 255; bias = 127; e = int'(w[62:55]); f = {41'd0, w[54:32]};
      end else begin
        fw = 52; emax = 2047; bias = 1023; e = int'(w[62:52]); f = {12'd0, w[51:0]};
      end
      if (e == emax) begin
        if (f == 0) r.cls = 3'd2;
        else begin
          r.mant = f << (62 - fw);
          if (f[fw-1]) r.cls = 3'd3;
          else begin
            r.cls = 3'd4; r.inv = 1'b1; r.mant[61] = 1'b1;
          end
        end
      end else if (e != 0 || f != 0) begin
        sig = (e != 0) ? ((64'd1 << fw) | f) : f;
        lsb = ((e != 0) ? e : 1) - bias - fw;
        num = 1'b1;
      end
    end
    if (num) begin
      for (int i = 0; i < 64; i++) if (sig[i]) p = i;
      r.cls  = 3'd1;
      r.mant = (p == 63) ? (sig >> 1) : (sig << (62 - p));
      r.exp  = 13'(lsb + p);
    end
    return r;
  endfunction

  task automatic send(input logic [2:0] k, input logic [63:0] w, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_kind  = k;
    in_word  = w;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
    exp_q.push_back(model(k, w));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic run_vectors();
    send(3'd0, 64'hDEAD_BEEF_0000_0000, "R4 int32 zero");
    send(3'd0, 64'h0000_0000_0000_0001, "R10 int32 one");
    send(3'd0, 64'h1234_5678_FFFF_FFFF, "R2 int32 minus one low word");
    send(3'd0, 64'h0000_0000_8000_0000, "R10 int32 most negative");
    send(3'd0, 64'h0000_0000_7FFF_FFFF, "R10 int32 max");
    send(3'd0, 64'hFFFF_FFFF_0000_3039, "R3 int32 ignores high word");
    send(3'd1, 64'h0000_0000_0000_0000, "R4 int64 zero");
    send(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R10 int64 minus one");
    send(3'd1, 64'h8000_0000_0000_0000, "R10 int64 most negative");
    send(3'd1, 64'h7FFF_FFFF_FFFF_FFFF, "R10 int64 max");
    send(3'd1, 64'h0000_0000_0000_0005, "R11 int64 five");
    send(3'd2, 64'h3F80_0000_1111_1111, "R5 single one");
    send(3'd2, 64'hC049_0FDB_0000_0000, "R5 single negative");
    send(3'd2, 64'h0000_0001_FFFF_FFFF, "R6 single min subnormal");
    send(3'd2, 64'h0040_0000_0000_0000, "R6 single subnormal");
    send(3'd2, 64'h7F80_0000_0000_0000, "R7 single inf");
    send(3'd2, 64'hFF80_0000_0000_0000, "R7 single neg inf");
    send(3'd2, 64'h7FC0_0001_0000_0000, "R8 single qnan");
    send(3'd2, 64'h7F80_0001_0000_0000, "R9 single snan");
    send(3'd2, 64'h8000_0000_0000_0000, "R4 single neg zero");
    send(3'd3, 64'h3FF0_0000_0000_0000, "R5 double one");
    send(3'd3, 64'hC37F_FFFF_FFFF_FFF1, "R5 double large");
    send(3'd3, 64'h0000_0000_0000_0001, "R6 double low-word subnormal");
    send(3'd3, 64'h000F_FFFF_FFFF_FFFF, "R6 double max subnormal");
    send(3'd3, 64'h7FF0_0000_0000_0000, "R7 double inf");
    send(3'd3, 64'h7FF8_0000_0000_0000, "R8 double qnan");
    send(3'd3, 64'h7FF0_0000_0000_0001, "R9 double snan low word");
    send(3'd3, 64'hFFF0_0001_0000_0000, "R9 double snan high frac");
    send(3'd3, 64'h8000_0000_0000_0000, "R4 double neg zero");
    send(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, "R3 bad kind 4");
    send(3'd7, 64'h3FF0_0000_0000_0000, "R3 bad kind 7");
  endtask

  // Monitor and scoreboard.
  initial begin
    res_t  act, want, held;
    logic  holding;
    string t;
    holding = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      out_ready = bp_en ? ($urandom_range(0, 2) == 0) : 1'b1;
      #1;
      act = {out_sign, out_exp, out_mant, out_class, out_invalid, out_bad_type};
      if (holding && rst_n) begin
        total++;
        if (!out_valid || act != held) begin
          bad++;
          $display("FAIL R1 held result changed: act=%h exp=%h valid=%0b", act, held, out_valid);
        end
      end
      holding = rst_n && out_valid && !out_ready;
      held = act;
      if (rst_n && out_valid && out_ready) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R1 unexpected result: act=%h exp=none", act);
        end else begin
          want = exp_q.pop_front();
          t = tag_q.pop_front();
          if (act != want) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", t, act, want);
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #3;
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset state: act=%b%b exp=01", out_valid, in_ready);
    end
    run_vectors();
    bp_en = 1'b1;
    run_vectors();
    while (exp_q.size() != 0) @(negedge clk);
    bp_en = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule